// File: doc/BRIEF.md
# Mixed-Length Instruction Format Classifier

This block sits between instruction fetch and decode in a core whose instruction stream mixes 16-bit and 32-bit encodings. Each input transfer carries four fetched bytes, in the order they appear in memory, together with bit 1 of their fetch address. The block puts the bytes into a word using the memory image's endianness, which is a static input. It then decides whether the word holds one 32-bit instruction, two 16-bit instructions that issue together, or one 16-bit instruction.

A 32-bit result carries a 30-bit payload with both halfword marker bits removed. A 16-bit result carries its halfword zero-extended to 30 bits. A pair leaves the block as two beats, upper halfword first. Each beat carries a format code and the number of bytes the fetch address should advance by. Both edges use valid/ready handshakes, and a result appears one cycle after its input is accepted.

Top module: `ifc_format_classifier`

## Requirements
- R1: When `in_addr_b1` is 1, the transfer is always one 16-bit instruction (format 0, length 2), built from the first two bytes only; bytes 2 and 3 have no effect on the output.
- R2: With `in_addr_b1` at 0, a word whose bit 31 and bit 15 are both set gives one beat with format code 2 and length 4.
- R3: The 30-bit payload of a format-2 beat is word bits 30:16 placed above word bits 14:0.
- R4: With `in_addr_b1` at 0, a word with bit 15 set and bit 31 clear gives two beats with format code 1. The first carries bits 31:16 with length 0, and the next carries bits 15:0 with length 4.
- R5: With `in_addr_b1` at 0, a word with bit 15 clear gives one beat with format code 0 and length 2, whose halfword is built from the first two bytes only.
- R6: Byte k of the transfer is `in_bytes[8k+7:8k]`. With `big_endian` at 0, byte 0 is the least significant byte of the word and of a halfword; with `big_endian` at 1, byte 0 is the most significant.
- R7: `out_valid` rises on the cycle after an input is accepted, when the output register is free. While `out_valid` is high and `out_ready` is low, the format, length and payload hold steady.
- R8: `in_ready` is low while the second beat of a pair is waiting, and whenever the output holds a beat that is not being taken.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.
- R10: For format codes 0 and 1, payload bits 29:16 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Static byte order of the memory image (1 = big-endian) |
| in_valid | input | 1 | Fetched bytes are offered |
| in_ready | output | 1 | Block accepts the offered bytes this cycle |
| in_bytes | input | 32 | Four fetched bytes, byte k in bits 8k+7:8k |
| in_addr_b1 | input | 1 | Bit 1 of the fetch address (1 = only a halfword is available) |
| out_valid | output | 1 | A classified beat is present |
| out_ready | input | 1 | Downstream takes the beat this cycle |
| out_fmt | output | 2 | 0 = single 16-bit, 1 = pair half, 2 = 32-bit |
| out_len | output | 3 | Bytes to advance the fetch address by (0, 2 or 4) |
| out_payload | output | 30 | Normalized instruction payload |

## Verification
A corrupted pending-half register shows up on the next beat after the first half of a pair is taken: the second half arrives late, repeats, or carries the wrong halfword. A stuck output register shows up as `out_valid` or `in_ready` departing from the queue occupancy that the reference model predicts, and this is detectable on the very next cycle. Classification or byte-order faults appear in the fields of the first beat produced from the affected input. Random backpressure exercises the stall and pending paths under both byte orders.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int NBYTES  = WORD_W / BYTE_W;
    localparam int PAY_W   = WORD_W - 2;
    localparam int LEN_W   = 3;
    localparam int MARK_LO = HALF_W - 1;
    localparam int MARK_HI = WORD_W - 1;

    typedef enum logic [1:0] {
        FMT_SHORT = 2'd0,
        FMT_PAIR  = 2'd1,
        FMT_WIDE  = 2'd2
    } fmt_e;

    typedef struct packed {
        logic             valid;
        fmt_e             fmt;
        logic [LEN_W-1:0] len;
        logic [PAY_W-1:0] pay;
    } beat_t;

    typedef struct packed {
        logic              valid;
        logic [HALF_W-1:0] half;
    } hold_t;
endpackage

// File: rtl/ifc_byte_order.sv
module ifc_byte_order
    import ifc_pkg::*;
(
    input  logic              big_endian,
    input  logic [WORD_W-1:0] bytes_i,
    output logic [WORD_W-1:0] word_o,
    output logic [HALF_W-1:0] half_o
);
    logic [WORD_W-1:0] le_word;
    logic [WORD_W-1:0] be_word;

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign le_word[k*BYTE_W +: BYTE_W] = bytes_i[k*BYTE_W +: BYTE_W];
        assign be_word[k*BYTE_W +: BYTE_W] = bytes_i[(NBYTES-1-k)*BYTE_W +: BYTE_W];
    end

    always_comb begin
        word_o = big_endian ? be_word : le_word;
        half_o = big_endian ? {bytes_i[0 +: BYTE_W], bytes_i[BYTE_W +: BYTE_W]}
                            : bytes_i[0 +: HALF_W];
    end
endmodule

// File: rtl/ifc_classify.sv
module ifc_classify
    import ifc_pkg::*;
(
    input  logic              half_only,
    input  logic [WORD_W-1:0] word_i,
    input  logic [HALF_W-1:0] half_i,
    output beat_t             first_o,
    output hold_t             second_o
);
    logic mark_hi;
    logic mark_lo;

    always_comb begin
        mark_hi = word_i[MARK_HI];
        mark_lo = word_i[MARK_LO];

        first_o.valid = 1'b1;
        first_o.fmt   = FMT_SHORT;
        first_o.len   = LEN_W'(2);
        first_o.pay   = {{(PAY_W-HALF_W){1'b0}}, half_i};
        second_o      = '0;

        if (!half_only && mark_lo) begin
            if (mark_hi) begin
                first_o.fmt = FMT_WIDE;
                first_o.len = LEN_W'(4);
                first_o.pay = {word_i[MARK_HI-1:HALF_W], word_i[MARK_LO-1:0]};
            end else begin
                first_o.fmt     = FMT_PAIR;
                first_o.len     = '0;
                first_o.pay     = {{(PAY_W-HALF_W){1'b0}}, word_i[WORD_W-1:HALF_W]};
                second_o.valid  = 1'b1;
                second_o.half   = word_i[HALF_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ifc_format_classifier.sv
module ifc_format_classifier
    import ifc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_bytes,
    input  logic              in_addr_b1,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_fmt,
    output logic [LEN_W-1:0]  out_len,
    output logic [PAY_W-1:0]  out_payload
);
    typedef struct packed {
        beat_t out;
        hold_t hold;
    } state_t;

    state_t            st_d, st_q;
    logic [WORD_W-1:0] word_w;
    logic [HALF_W-1:0] half_w;
    beat_t             first_w;
    hold_t             second_w;
    logic              out_free;
    logic              rdy_d;

    ifc_byte_order u_order (
        .big_endian (big_endian),
        .bytes_i    (in_bytes),
        .word_o     (word_w),
        .half_o     (half_w)
    );

    ifc_classify u_class (
        .half_only (in_addr_b1),
        .word_i    (word_w),
        .half_i    (half_w),
        .first_o   (first_w),
        .second_o  (second_w)
    );

    always_comb begin
        st_d     = st_q;
        out_free = !st_q.out.valid || out_ready;
        rdy_d    = out_free && !st_q.hold.valid;
        if (out_free) begin
            if (st_q.hold.valid) begin
                st_d.out.valid  = 1'b1;
                st_d.out.fmt    = FMT_PAIR;
                st_d.out.len    = LEN_W'(4);
                st_d.out.pay    = {{(PAY_W-HALF_W){1'b0}}, st_q.hold.half};
                st_d.hold.valid = 1'b0;
            end else if (in_valid) begin
                st_d.out       = first_w;
                st_d.out.valid = 1'b1;
                st_d.hold      = second_w;
            end else begin
                st_d.out.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready    = rdy_d;
    assign out_valid   = st_q.out.valid;
    assign out_fmt     = st_q.out.fmt;
    assign out_len     = st_q.out.len;
    assign out_payload = st_q.out.pay;

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_fmt)
                                    && $stable(out_len) && $stable(out_payload));
    // R8
    pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hold.valid |-> !in_ready);
    // R4
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_fmt == FMT_PAIR && out_len == 0
        |=> out_valid && out_fmt == FMT_PAIR && out_len == LEN_W'(4));
    // R10
    short_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fmt != FMT_WIDE |-> out_payload[PAY_W-1:HALF_W] == '0);
    // R5
    short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fmt == FMT_SHORT |-> out_len == LEN_W'(2));
endmodule

// File: tb/ifc_format_classifier_tb.sv
module ifc_format_classifier_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_bytes = '0;
    logic        in_addr_b1 = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_fmt;
    logic [2:0]  out_len;
    logic [29:0] out_payload;

    int total = 0;
    int bad   = 0;
    logic [34:0] q[$];

    always #5 clk = ~clk;

    ifc_format_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .in_valid(in_valid), .in_ready(in_ready), .in_bytes(in_bytes),
        .in_addr_b1(in_addr_b1), .out_valid(out_valid), .out_ready(out_ready),
        .out_fmt(out_fmt), .out_len(out_len), .out_payload(out_payload)
    );

    task automatic chk(input logic ok, input string tag, input logic [34:0] act, input logic [34:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s be=%0d actual=%h expected=%h", tag, big_endian, act, exp);
        end
    endtask

    // expected beats: {fmt, len, payload}
    task automatic model(input logic [31:0] b, input logic a1, input logic be);
        logic [31:0] w;
        logic [15:0] h;
        w = be ? {b[7:0], b[15:8], b[23:16], b[31:24]} : b;
        h = be ? {b[7:0], b[15:8]} : b[15:0];
        if (a1 || !w[15]) q.push_back({2'd0, 3'd2, 14'd0, h});
        else if (w[31]) q.push_back({2'd2, 3'd4, w[30:16], w[14:0]});
        else begin
            q.push_back({2'd1, 3'd0, 14'd0, w[31:16]});
            q.push_back({2'd1, 3'd4, 14'd0, w[15:0]});
        end
    endtask

    function automatic string tag_of(input logic [1:0] f, input logic a1);
        if (f == 2'd2) return "R2/R3/R6";
        if (f == 2'd1) return "R4/R6/R10";
        return a1 ? "R1/R6/R10" : "R5/R6/R10";
    endfunction

    logic [31:0] dir_b [8];
    logic        dir_a [8];
    logic        a1_q[$];

    initial begin
        dir_b[0] = 32'h8123_8456; dir_a[0] = 1'b0;
        dir_b[1] = 32'h1234_8678; dir_a[1] = 1'b0;
        dir_b[2] = 32'h8000_1234; dir_a[2] = 1'b0;
        dir_b[3] = 32'hFFFF_8001; dir_a[3] = 1'b1;  // R1: upper bytes ignored
        dir_b[4] = 32'h0080_0080; dir_a[4] = 1'b0;
        dir_b[5] = 32'h8080_8080; dir_a[5] = 1'b0;
        dir_b[6] = 32'h7FFF_FFFF; dir_a[6] = 1'b0;
        dir_b[7] = 32'hFFFF_FFFF; dir_a[7] = 1'b0;
    end

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int ph = 0; ph < 2; ph++) begin
            logic fired;
            int   idx;
            @(negedge clk);
            rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
            big_endian = ph[0];
            q.delete(); a1_q.delete();
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            #1;
            // R9 reset state
            chk(out_valid == 1'b0, "R9 out_valid", {34'd0, out_valid}, 35'd0);
            chk(in_ready == 1'b1, "R9 in_ready", {34'd0, in_ready}, 35'd1);
            fired = 1'b1;
            idx = 0;
            for (int cyc = 0; cyc < 1500; cyc++) begin
                @(negedge clk);
                if (fired || !in_valid) begin
                    if (idx < 8) begin
                        in_valid = 1'b1; in_bytes = dir_b[idx]; in_addr_b1 = dir_a[idx];
                        idx++;
                    end else begin
                        in_valid   = ($urandom % 4) != 0;
                        in_bytes   = $urandom;
                        in_addr_b1 = ($urandom % 4) == 0;
                    end
                end
                out_ready = (cyc < 40) ? (cyc % 5 != 0) : (($urandom % 3) != 0);
                fired = 1'b0;
                #1;
                // R7: output present exactly when the model holds a beat
                chk(out_valid == (q.size() != 0), "R7 out_valid",
                    {34'd0, out_valid}, {34'd0, q.size() != 0});
                // R8: ready only when nothing pending and output can move
                chk(in_ready == ((q.size() == 0) || (q.size() == 1 && out_ready)),
                    "R8 in_ready", {34'd0, in_ready},
                    {34'd0, (q.size() == 0) || (q.size() == 1 && out_ready)});
                if (out_valid && out_ready && q.size() != 0) begin
                    chk({out_fmt, out_len, out_payload} == q[0],
                        tag_of(q[0][34:33], a1_q[0]), {out_fmt, out_len, out_payload}, q[0]);
                    if (q[0][34:33] != 2'd1 || q[0][32:30] != 3'd0) void'(a1_q.pop_front());
                    void'(q.pop_front());
                end
                if (in_valid && in_ready) begin
                    model(in_bytes, in_addr_b1, big_endian);
                    a1_q.push_back(in_addr_b1);
                    fired = 1'b1;
                end
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule